// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This controller burns an image into a one-time-programmable byte memory and then confirms it. A single start strobe launches a run. The run walks the addresses from zero up to a last address supplied on an input. At every address the sequencer raises its high-voltage request and applies one program pulse of fixed length. It then reads the byte back with the high voltage still present. A byte that has not taken receives another pulse and another read, until it matches or the per-byte retry budget is spent.

Once every byte has verified, the sequencer drops the high-voltage request and reads the whole range once more at normal supply. Any difference ends the run with the fail flag. A clean sweep ends it with the pass flag. The image comes from an external source addressed by the sequencer, and the memory is driven through a simple command port.

Top module: `otp_prog_seq`

## Requirements
- R1: Out of reset the sequencer is idle, with busy, pass, fail, memory enable and high-voltage request all low.
- R2: Each program pulse (enable high, read/not-write low) lasts exactly PULSE_CYC consecutive cycles, and the high-voltage request is high throughout it.
- R3: A byte that takes after n pulses, with n at most MAX_TRY, receives exactly n pulses. Each pulse is followed by one verify read, which has enable high, read/not-write high and the high-voltage request high.
- R4: Every read holds enable and read/not-write high for RD_CYC cycles. The read data is taken only on the final cycle of the read, so values on earlier cycles have no effect.
- R5: If a byte still mismatches after MAX_TRY pulses, the run ends with fail set. No later address is pulsed, and no normal-voltage readback takes place.
- R6: When all bytes have verified, every address from 0 to the last address is read once in ascending order with the high-voltage request low. The run ends with pass if all bytes match.
- R7: A mismatch in the normal-voltage readback ends the run with fail set at that address, and no further addresses are read.
- R8: A start strobe while busy is ignored. Pass and fail are cleared when a run is accepted, and they are never high together.
- R9: Addresses above last_addr_i, which must stay stable during a run, are never accessed. A last address of 0 programs a single byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| last_addr_i | input | ADDR_W | Highest address to program |
| img_addr_o | output | ADDR_W | Address presented to the image source |
| img_data_i | input | DATA_W | Image byte for img_addr_o (combinational) |
| mem_en_o | output | 1 | Memory access active |
| mem_rnw_o | output | 1 | 1 = read/verify, 0 = program |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Data to program |
| mem_rdata_i | input | DATA_W | Read data from memory |
| hv_req_o | output | 1 | Request for high programming voltage |
| busy_o | output | 1 | Run in progress |
| pass_o | output | 1 | Last run passed |
| fail_o | output | 1 | Last run failed |

## Verification
Two decisions can land on the same verify cycle: the retry budget running out and the last address being reached. The bench provokes this by giving the final byte a take count equal to the budget, and separately by making a mid-range byte need one pulse more than the budget. It then judges the run from the per-address pulse counts it observes and from whether any normal-voltage reads occurred. A second overlap, a start strobe arriving while a run is active, is injected mid-run. It is judged by the run's pulse and read counts staying exactly as computed for a single run.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PROG = 2'd1,
    S_VFY  = 2'd2,
    S_CHK  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [TW-1:0] term_i,
  output logic          last_o
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign last_o = run_i && (cnt_q == term_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || last_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2/R4: the count never passes the terminal value while running
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> cnt_q <= term_i);
endmodule

// File: rtl/otp_try_counter.sv
module otp_try_counter #(
  parameter int MAX_TRY = 10,
  localparam int CW = $clog2(MAX_TRY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRY);
  logic [CW-1:0] cnt_q, cnt_d;

  assign at_limit_o = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (inc_i && !at_limit_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_try_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_no_inc_past_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit_o && !clr_i |=> at_limit_o);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 4096,
  parameter int RD_CYC    = 2,
  parameter int MAX_TRY   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] last_addr_i,
  output logic [ADDR_W-1:0] img_addr_o,
  input  logic [DATA_W-1:0] img_data_i,
  output logic              mem_en_o,
  output logic              mem_rnw_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              hv_req_o,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int TMAX = (PULSE_CYC > RD_CYC) ? PULSE_CYC : RD_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0]     PULSE_TERM = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0]     READ_TERM  = TW'(RD_CYC - 1);
  localparam logic [ADDR_W-1:0] A_ONE      = ADDR_W'(1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              pass_q, pass_d, fail_q, fail_d;
  logic              ph_last, try_clr, try_inc, try_full;
  logic              is_prog, is_vfy, is_chk, match, at_end;

  assign is_prog = (state_q == S_PROG);
  assign is_vfy  = (state_q == S_VFY);
  assign is_chk  = (state_q == S_CHK);
  assign match   = (mem_rdata_i == img_data_i);
  assign at_end  = (addr_q == last_addr_i);

  otp_phase_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run_i(busy_o),
    .term_i(is_prog ? PULSE_TERM : READ_TERM), .last_o(ph_last));

  otp_try_counter #(.MAX_TRY(MAX_TRY)) u_try (
    .clk(clk), .rst_n(rst_n), .clr_i(try_clr), .inc_i(try_inc),
    .at_limit_o(try_full));

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    pass_d  = pass_q;
    fail_d  = fail_q;
    try_clr = 1'b0;
    try_inc = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        addr_d  = '0;
        pass_d  = 1'b0;
        fail_d  = 1'b0;
        try_clr = 1'b1;
        state_d = S_PROG;
      end
      S_PROG: if (ph_last) begin
        try_inc = 1'b1;
        state_d = S_VFY;
      end
      S_VFY: if (ph_last) begin
        if (match) begin
          try_clr = 1'b1;
          if (at_end) begin
            addr_d  = '0;
            state_d = S_CHK;
          end else begin
            addr_d  = addr_q + A_ONE;
            state_d = S_PROG;
          end
        end else if (try_full) begin
          fail_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_PROG;
        end
      end
      S_CHK: if (ph_last) begin
        if (!match) begin
          fail_d  = 1'b1;
          state_d = S_IDLE;
        end else if (at_end) begin
          pass_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          addr_d  = addr_q + A_ONE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign hv_req_o    = is_prog || is_vfy;
  assign mem_en_o    = busy_o;
  assign mem_rnw_o   = !is_prog;
  assign mem_addr_o  = addr_q;
  assign img_addr_o  = addr_q;
  assign mem_wdata_o = img_data_i;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;

  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
  p_hv_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_o && !mem_rnw_o |-> hv_req_o);
  p_prog_to_vfy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_prog && !mem_rnw_o && ph_last |=> mem_en_o && mem_rnw_o && hv_req_o);
  p_addr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> addr_q <= last_addr_i);
  p_chk_lowv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_chk |-> !hv_req_o && mem_rnw_o);
  p_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> pass_o || fail_o);
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !ph_last |=> $stable(addr_q));
endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int AW = 4, DW = 8, PC = 3, RC = 2, MT = 4, N = 16;

  logic clk, rst_n, start;
  logic [AW-1:0] last_addr, img_addr, mem_addr;
  logic [DW-1:0] img_data, wdata, rdata;
  logic en, rnw, hv, busy, pass, fail;
  int checks, errors;

  int need [N];
  bit corrupt [N];
  int pulses [N];
  int lowv_reads [N];
  bit touched [N];
  int run_len, rd_phase, prog_addr;
  logic [DW-1:0] seed;

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .RD_CYC(RC),
                 .MAX_TRY(MT)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .last_addr_i(last_addr),
    .img_addr_o(img_addr), .img_data_i(img_data), .mem_en_o(en),
    .mem_rnw_o(rnw), .mem_addr_o(mem_addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .hv_req_o(hv), .busy_o(busy), .pass_o(pass),
    .fail_o(fail));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] img_f(input int a);
    return (DW'(a * 37) ^ seed) | 8'h80;
  endfunction

  assign img_data = img_f(int'(img_addr));

  always_comb begin
    logic [DW-1:0] v;
    v = (pulses[mem_addr] >= need[mem_addr]) ? img_f(int'(mem_addr)) : '0;
    if (!hv && corrupt[mem_addr]) v = v ^ 8'h01;
    if (rd_phase != RC - 1) v = ~v;   // R4: only the final read cycle is valid
    rdata = v;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && en) begin
      touched[mem_addr] = 1'b1;
      if (!rnw) begin
        run_len++;
        prog_addr = int'(mem_addr);
        if (!hv) begin checks++; errors++; $display("FAIL R2 actual=hv0 expected=hv1"); end
      end
    end
    if (!(rst_n && en && !rnw) && run_len != 0) begin
      chk(run_len == PC, "R2 pulse length", run_len, PC);
      pulses[prog_addr]++;
      run_len = 0;
    end
    if (rst_n && en && rnw) begin
      if (rd_phase == RC - 1) begin
        if (!hv) lowv_reads[mem_addr]++;
        rd_phase = 0;
      end else rd_phase++;
    end else rd_phase = 0;
  end

  task automatic clear_model();
    for (int a = 0; a < N; a++) begin
      need[a] = 1; corrupt[a] = 1'b0; pulses[a] = 0;
      lowv_reads[a] = 0; touched[a] = 1'b0;
    end
  endtask

  task automatic run(input int last, input bit poke, input string tag);
    int k, cor, t;
    bit exp_pass;
    @(negedge clk);
    last_addr = AW'(last);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && !fail, "R8 flags cleared at start", {busy, pass, fail}, 3'b100);
    t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
      if (poke && t == 7) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (t >= 5000) begin checks++; errors++; $display("FAIL watchdog %s actual=busy expected=idle", tag); end
    k = -1;
    for (int a = 0; a <= last; a++) if (k < 0 && need[a] > MT) k = a;
    cor = -1;
    for (int a = 0; a <= last; a++) if (cor < 0 && corrupt[a]) cor = a;
    exp_pass = (k < 0) && (cor < 0);
    chk(pass == exp_pass && fail == !exp_pass, {tag, " R5 R6 R7 result"}, {pass, fail}, {exp_pass, !exp_pass});
    for (int a = 0; a < N; a++) begin
      int ep, er;
      if (a > last) begin ep = 0; er = 0; end
      else if (k >= 0) begin ep = (a < k) ? need[a] : (a == k ? MT : 0); er = 0; end
      else begin ep = need[a]; er = (cor < 0 || a <= cor) ? 1 : 0; end
      chk(pulses[a] == ep, {tag, " R3 R5 pulses per address"}, pulses[a], ep);
      chk(lowv_reads[a] == er, {tag, " R6 R7 R4 readback count"}, lowv_reads[a], er);
      if (a > last) chk(!touched[a], {tag, " R9 untouched above last"}, touched[a], 0);
    end
  endtask

  initial begin
    checks = 0; errors = 0; run_len = 0; rd_phase = 0; prog_addr = 0;
    start = 1'b0; last_addr = '0; seed = 8'h15;
    clear_model();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !pass && !fail && !en && !hv, "R1 reset state", {busy, pass, fail, en, hv}, 0);
    rst_n = 1'b1;

    clear_model(); run(3, 1'b0, "all-one");
    clear_model(); seed = 8'h2a;
    for (int a = 0; a < N; a++) need[a] = (a % MT) + 1;
    run(15, 1'b1, "R8 mixed with start poke");
    clear_model(); need[5] = MT + 1; run(9, 1'b0, "R5 budget out mid");
    clear_model(); need[15] = MT; run(15, 1'b0, "R3 budget at last");
    clear_model(); need[15] = MT + 1; run(15, 1'b0, "R5 budget out at last");
    clear_model(); corrupt[6] = 1'b1; need[2] = 3; run(10, 1'b0, "R7 low voltage mismatch");
    clear_model(); seed = 8'h5c; run(0, 1'b0, "R9 single byte");
    clear_model(); corrupt[0] = 1'b1; run(0, 1'b0, "R7 first byte");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule